// File: doc/BRIEF.md
# Supply Monitor Control Register

This block is the 16-bit control and status register for a supply-voltage monitor, together with the logic for readiness and interrupts. Software programs a 4-bit threshold code and sets enable bits. The block then compares a digital supply-level code, given in tenths of a volt, against the trip level. The trip level in tenths of a volt is 20 plus the threshold code. When the supply falls under that level, a sticky flag is set and can raise an interrupt.

After the monitor becomes active it waits through a warm-up period, counted in clock cycles, before it reports ready. Only a ready monitor can set the flag. In stop mode the monitor keeps running only if its stop-mode enable is set. Otherwise it goes inactive and must warm up again when stop mode ends. The analog comparator, the voltage reference and the processor are outside the block; they appear only as input ports.

Top module: `supmon_ctrl`

## Requirements
- R1: After reset, rd_data reads 16'h0700 (threshold code 7, every other bit 0) and irq is 0.
- R2: Bits 15:12 and 7:5 always read 0. Writing ones to them changes no readable state.
- R3: A write updates the threshold field (bits 11:8) only when the enable bit (bit 0) currently holds 0. While the enable bit is 1, threshold writes are dropped. The write that sets the enable bit can still load the threshold.
- R4: The ready bit (bit 1, read-only) reads 0 while the monitor is inactive. It reads 1 once the monitor has been active for WARMUP_CYCLES consecutive clock edges.
- R5: When stop_mode is 1 and the stop-mode enable (bit 4) is 0, the monitor is inactive: ready reads 0 and the flag is not set by hardware. When the stop-mode enable is 1, stop_mode has no effect.
- R6: While ready is 1, the flag (bit 3) is set on the next edge if supply_code < 20 + threshold code. A supply code equal to the trip level does not set it.
- R7: A write loads bit 3 into the flag, so software can set it or clear it. If hardware sets the flag in the same cycle, hardware wins, so a clear while the supply is low leaves the flag reading 1.
- R8: irq equals flag AND interrupt enable (bit 2), whatever the state of ready and enable. A flag set by software while the monitor is disabled still interrupts.
- R9: Warm-up restarts from zero each time the monitor goes from inactive to active. This covers both setting the enable bit and leaving stop mode when the stop-mode enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 16 | Full write word |
| rd_data | output | 16 | Combinational register read value |
| stop_mode | input | 1 | Processor is in stop mode |
| supply_code | input | SUP_W | Measured supply in tenths of a volt |
| irq | output | 1 | Level interrupt request |

## Verification
The hardware set of the flag and a software write to the flag can happen in the same cycle. So can a threshold write and the write that sets or holds the enable bit. The bench provokes the first on purpose: it clears the flag while the supply is held under the trip level with the monitor ready, and it also clears the flag with the supply exactly at the trip level. It provokes the second by rewriting the threshold in the same word that keeps enable at 1. Random cycles then mix writes, supply codes and stop-mode toggles. A cycle model built from the requirements judges every cycle and expects the hardware set to win and the locked threshold to stay unchanged.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
   localparam int REG_W     = 16;
   localparam int B_EN      = 0;
   localparam int B_READY   = 1;
   localparam int B_IE      = 2;
   localparam int B_FLAG    = 3;
   localparam int B_STOPEN  = 4;
   localparam int THR_LSB   = 8;
   localparam int THR_W     = 4;
   localparam int THR_BASE  = 20;
   localparam logic [THR_W-1:0] THR_RST = 4'd7;
endpackage

// File: rtl/supmon_warmup.sv
module supmon_warmup #(
   parameter int WARMUP_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   output logic ready
);
   initial assert (WARMUP_CYCLES >= 0) else $error("WARMUP_CYCLES must be non-negative");

   generate
      if (WARMUP_CYCLES == 0) begin : g_instant
         assign ready = active;
      end else begin : g_count
         localparam int CNT_W = $clog2(WARMUP_CYCLES + 1);
         localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WARMUP_CYCLES);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (!active)       cnt_q <= '0;
            else if (cnt_q != CNT_END) cnt_q <= cnt_q + 1'b1;
         end

         assign ready = active && (cnt_q == CNT_END);

         // R9: an inactive cycle forces a fresh warm-up
         p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !active |=> !ready);
      end
   endgenerate
endmodule

// File: rtl/supmon_cmp.sv
module supmon_cmp #(
   parameter int SUP_W = 6,
   parameter int THR_W = 4,
   parameter int BASE  = 20
) (
   input  logic [SUP_W-1:0] supply,
   input  logic [THR_W-1:0] thr,
   output logic             below
);
   localparam int LIM = BASE + (1 << THR_W) - 1;
   localparam int LW  = $clog2(LIM + 1);
   localparam int CW  = (SUP_W > LW) ? SUP_W : LW;

   initial assert (SUP_W >= 1 && THR_W >= 1) else $error("bad compare widths");

   logic [CW-1:0] sup_ext, trip;
   assign sup_ext = CW'(supply);
   assign trip    = CW'(BASE) + CW'(thr);
   assign below   = sup_ext < trip;
endmodule

// File: rtl/supmon_flag.sv
module supmon_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic hw_set,
   input  logic wr_en,
   input  logic wr_val,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag <= 1'b0;
      else if (hw_set) flag <= 1'b1;
      else if (wr_en)  flag <= wr_val;
   end

   // R6: a hardware detection always lands in the flag
   p_hw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> flag);
   // R7: a software clear sticks when hardware is quiet
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_val && !hw_set) |=> !flag);
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
   import supmon_pkg::*;
#(
   parameter int SUP_W         = 6,
   parameter int WARMUP_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [15:0]      wr_data,
   output logic [15:0]      rd_data,
   input  logic             stop_mode,
   input  logic [SUP_W-1:0] supply_code,
   output logic             irq
);
   initial assert (REG_W == 16) else $error("register width must be 16");

   logic             en_q, ie_q, stopen_q;
   logic [THR_W-1:0] thr_q;
   logic             active, ready, below, hw_set, flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         ie_q     <= 1'b0;
         stopen_q <= 1'b0;
         thr_q    <= THR_RST;
      end else if (wr_en) begin
         en_q     <= wr_data[B_EN];
         ie_q     <= wr_data[B_IE];
         stopen_q <= wr_data[B_STOPEN];
         if (!en_q) thr_q <= wr_data[THR_LSB +: THR_W];
      end
   end

   assign active = en_q && (!stop_mode || stopen_q);

   supmon_warmup #(.WARMUP_CYCLES(WARMUP_CYCLES)) i_warmup (
      .clk(clk), .rst_n(rst_n), .active(active), .ready(ready));

   supmon_cmp #(.SUP_W(SUP_W), .THR_W(THR_W), .BASE(THR_BASE)) i_cmp (
      .supply(supply_code), .thr(thr_q), .below(below));

   assign hw_set = ready && below;

   supmon_flag i_flag (
      .clk(clk), .rst_n(rst_n), .hw_set(hw_set),
      .wr_en(wr_en), .wr_val(wr_data[B_FLAG]), .flag(flag));

   always_comb begin
      rd_data                      = '0;
      rd_data[B_EN]                = en_q;
      rd_data[B_READY]             = ready;
      rd_data[B_IE]                = ie_q;
      rd_data[B_FLAG]              = flag;
      rd_data[B_STOPEN]            = stopen_q;
      rd_data[THR_LSB +: THR_W]    = thr_q;
   end

   assign irq = flag && ie_q;

   // R3: threshold frozen across a write while enabled
   p_thr_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && en_q) |=> $stable(thr_q));
   // R5: stop mode without stop enable keeps the monitor unready
   p_stop_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_mode && !stopen_q) |-> !ready);
   // R4: ready only ever rises with the monitor enabled
   p_ready_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> en_q);
   // R8: an interrupt never rises without a set flag
   p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> rd_data[B_FLAG]);
endmodule

// File: tb/test_supmon_ctrl.sv
module test_supmon_ctrl;
   localparam int W = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        stop_mode = 1'b0;
   logic [5:0]  supply_code = 6'd40;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // cycle model from the requirements
   logic       m_en = 0, m_ie = 0, m_stop = 0, m_flag = 0;
   logic [3:0] m_thr = 4'd7;
   int         m_cnt = 0;

   always #5 clk = ~clk;

   supmon_ctrl #(.SUP_W(6), .WARMUP_CYCLES(W)) i_supmon_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .stop_mode(stop_mode), .supply_code(supply_code),
      .irq(irq));

   function automatic logic m_ready(input logic stp);
      return m_en && (!stp || m_stop) && (m_cnt == W);
   endfunction

   function automatic logic [15:0] m_read(input logic stp);
      return {4'b0, m_thr, 3'b0, m_stop, m_flag, m_ie, m_ready(stp), m_en};
   endfunction

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic we, input logic [15:0] wd, input int sup,
                      input logic stp, input string tag);
      logic act, rdy, hw;
      wr_en = we; wr_data = wd; supply_code = 6'(sup); stop_mode = stp;
      #1;
      check({tag, " rd"}, rd_data, m_read(stp));
      check({tag, " irq"}, {15'b0, irq}, {15'b0, m_flag & m_ie});
      act = m_en && (!stp || m_stop);
      rdy = m_ready(stp);
      hw  = rdy && (sup < 20 + int'(m_thr));
      @(posedge clk);
      if (!act) m_cnt = 0; else if (m_cnt != W) m_cnt++;
      if (hw) m_flag = 1'b1; else if (we) m_flag = wd[3];
      if (we) begin
         if (!m_en) m_thr = wd[11:8];
         m_en = wd[0]; m_ie = wd[2]; m_stop = wd[4];
      end
      #2;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      #12 rst_n = 1'b1;
      @(posedge clk); #2;
      // R1 reset state
      cyc(0, 16'h0, 40, 0, "R1 reset");
      // R2 reserved bits ignored, threshold 0 loaded
      cyc(1, 16'hF0E0, 40, 0, "R2 reserved write");
      cyc(0, 16'h0, 40, 0, "R2 reserved read");
      // R3 threshold 10 (trip 30) written while disabled, then enable
      cyc(1, 16'h0A00, 40, 0, "R3 thr load");
      cyc(1, 16'h0A01, 25, 0, "R3 enable");
      cyc(1, 16'h0301, 25, 0, "R3 locked write");
      // R4 warm-up with supply low: ready and flag stay 0 until done
      for (int i = 0; i < W + 2; i++) cyc(0, 16'h0, 25, 0, "R4 warmup");
      // R6 flag now set; R7 clear while low loses to hardware
      cyc(1, 16'h0001, 25, 0, "R7 clear while low");
      cyc(0, 16'h0, 25, 0, "R7 reasserted");
      // R6 equal to trip level does not set; clear then sticks
      cyc(1, 16'h0001, 30, 0, "R6 equal clear");
      cyc(0, 16'h0, 30, 0, "R6 equal no set");
      cyc(0, 16'h0, 29, 0, "R6 one below");
      cyc(0, 16'h0, 35, 0, "R6 set seen");
      // R8 software set with monitor disabled interrupts
      cyc(1, 16'h0000, 35, 0, "R8 disable");
      cyc(1, 16'h000C, 35, 0, "R8 soft set");
      cyc(0, 16'h0, 35, 0, "R8 irq level");
      cyc(1, 16'h0004, 35, 0, "R8 clear");
      // R5 stop mode without stop enable: inactive
      cyc(1, 16'h0001, 35, 0, "R5 enable");
      for (int i = 0; i < W + 1; i++) cyc(0, 16'h0, 35, 0, "R4 warmup2");
      for (int i = 0; i < 4; i++) cyc(0, 16'h0, 22, 1, "R5 stop gated");
      // R9 leaving stop restarts warm-up
      for (int i = 0; i < W + 2; i++) cyc(0, 16'h0, 35, 0, "R9 restart");
      // R5 stop enable keeps it running
      cyc(1, 16'h0011, 35, 0, "R5 stop enable");
      for (int i = 0; i < 3; i++) cyc(0, 16'h0, 22, 1, "R5 stop running");
      cyc(1, 16'h0011, 35, 1, "R7 clear ok");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic we, stp;
         logic [15:0] wd;
         int sup;
         we  = ($urandom_range(0, 7) == 0);
         wd  = 16'($urandom());
         if ($urandom_range(0, 3) != 0) wd[0] = 1'b1;
         sup = $urandom_range(18, 40);
         stp = ($urandom_range(0, 15) == 0);
         cyc(we, wd, sup, stp, "R8 random");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule